// File: doc/BRIEF.md
# Byte-Serial Counter Register Port

This block is the host side of one 24-bit counting channel, seen through an 8-bit bus with two addresses. The data address moves the 24-bit values one byte at a time: writes fill the preset register, reads drain the output latch. Both directions go least significant byte first through one shared byte pointer. That pointer advances on every data access and wraps after the third byte. The control address accepts command bytes on write and returns a flag byte on read.

A command byte carries a target in bits 6:5. Target 00 is a reset/load command that can, in one write, rewind the byte pointer, fire one reset action and perform one transfer. Targets 01, 10 and 11 load their five-bit payload into the mode, input/output-control and index-control registers. Those registers reach the counting core as configuration fields. The resets and the preset-to-counter transfer reach the core as one-cycle strobes. The core returns its live count and its four flags.

The byte pointer is a three-state machine: `PTR_LOW`, `PTR_MID` and `PTR_HIGH`. It has two named transitions. ADVANCE moves LOW to MID, MID to HIGH and HIGH to LOW on any data-address read or write. REWIND forces LOW on a reset/load command with bit 0 set.

Top module: `ctr_byte_port`

## Requirements
- R1: After reset the byte pointer is at the low byte, the preset, output latch, prescaler, mode, I/O-control and index-control registers are zero, and no command strobe is active.
- R2: Three data-address writes after a pointer rewind load preset bits 7:0, 15:8 and 23:16 in that order; the preset does not change without a data-address write, and data-address reads leave it unchanged.
- R3: The byte pointer wraps from the high byte back to the low byte, so a fourth data write lands in preset bits 7:0.
- R4: A reset/load command (bits 6:5 = 00) with bit 0 set returns the pointer to the low byte before any transfer in the same command is used, so the next data read returns latch bits 7:0; without bit 0 the pointer keeps its position.
- R5: In a reset/load command, bits 2:1 = 01 pulses the counter-reset strobe, 10 the flag-clear strobe (borrow, carry, compare, sign), and 11 the error-clear strobe, each for exactly the one cycle after the write; 00 pulses none.
- R6: In a reset/load command, bits 4:3 = 01 pulses the preset-to-counter strobe, 10 copies the core count into the output latch on the write edge (the value before any reset in the same command takes effect), and 11 copies preset bits 7:0 into the prescaler register.
- R7: Three data-address reads after a latch-and-rewind command return latch bits 7:0, 15:8 and 23:16 in that order.
- R8: A read at the control address returns borrow in bit 0, carry in bit 1, error in bit 4 and up/down in bit 5, with all other bits zero.
- R9: A control write with bits 6:5 = 01, 10 or 11 loads bits 4:0 into the mode, I/O-control or index-control register respectively; bit 7 is ignored and the other two registers keep their values.
- R10: A reset/load command leaves the mode, I/O-control and index-control registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed byte |
| bus_rd | input | 1 | Read strobe for the addressed byte |
| bus_addr | input | 1 | 0 = data address, 1 = control/status address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data: latch byte at the pointer, or the flag byte |
| core_count | input | 24 | Live count from the counting core |
| core_borrow | input | 1 | Borrow toggle flag from the core |
| core_carry | input | 1 | Carry toggle flag from the core |
| core_error | input | 1 | Error flag from the core |
| core_up | input | 1 | Count direction flag from the core (1 = up) |
| cmd_cnt_reset | output | 1 | One-cycle strobe: clear the counter |
| cmd_flag_clear | output | 1 | One-cycle strobe: clear borrow, carry, compare and sign |
| cmd_err_clear | output | 1 | One-cycle strobe: clear the error flag |
| cmd_preset_load | output | 1 | One-cycle strobe: copy the preset into the counter |
| preset_value | output | 24 | Preset register |
| psc_value | output | 8 | Filter prescaler register |
| mode_cfg | output | 5 | Mode register payload |
| ioc_cfg | output | 5 | I/O-control register payload |
| idx_cfg | output | 5 | Index-control register payload |

## Verification
One command byte can rewind the pointer, clear the counter and capture the count into the latch in the same write. That makes a race between the capture and the reset, and between the rewind and the byte selection of the reads that follow. The bench loads a known nonzero count, sends one byte with all three actions, and reads three bytes. It expects the count as it was before the reset, in low-to-high order, and expects the core to show zero afterwards. A separate case reads one byte first and then issues a latch command without rewind, to show that the pointer position survives a transfer.

// File: rtl/ctr_port_pkg.sv
package ctr_port_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_BYTES = 3;
    localparam int VAL_W     = BYTE_W * NUM_BYTES;
    localparam int PAY_W     = BYTE_W - 3;

    typedef enum logic [1:0] {
        PTR_LOW  = 2'd0,
        PTR_MID  = 2'd1,
        PTR_HIGH = 2'd2
    } byte_ptr_e;

    typedef enum logic [1:0] {
        TGT_CMD  = 2'd0,
        TGT_MODE = 2'd1,
        TGT_IOC  = 2'd2,
        TGT_IDX  = 2'd3
    } ctl_target_e;

    typedef struct packed {
        logic             rewind;
        logic             rst_cnt;
        logic             clr_flags;
        logic             clr_err;
        logic             xfer_preset;
        logic             xfer_latch;
        logic             xfer_psc;
        logic             ld_mode;
        logic             ld_ioc;
        logic             ld_idx;
        logic [PAY_W-1:0] payload;
    } ctl_dec_t;
endpackage

// File: rtl/ctr_ctl_decode.sv
module ctr_ctl_decode
    import ctr_port_pkg::*;
(
    input  logic              ctl_valid,
    input  logic [BYTE_W-1:0] ctl_byte,
    output ctl_dec_t          dec
);
    always_comb begin
        dec         = '0;
        dec.payload = ctl_byte[PAY_W-1:0];
        if (ctl_valid) begin
            unique case (ctl_target_e'(ctl_byte[6:5]))
                TGT_CMD: begin
                    dec.rewind = ctl_byte[0];
                    unique case (ctl_byte[2:1])
                        2'b01:   dec.rst_cnt   = 1'b1;
                        2'b10:   dec.clr_flags = 1'b1;
                        2'b11:   dec.clr_err   = 1'b1;
                        default: ;
                    endcase
                    unique case (ctl_byte[4:3])
                        2'b01:   dec.xfer_preset = 1'b1;
                        2'b10:   dec.xfer_latch  = 1'b1;
                        2'b11:   dec.xfer_psc    = 1'b1;
                        default: ;
                    endcase
                end
                TGT_MODE: dec.ld_mode = 1'b1;
                TGT_IOC:  dec.ld_ioc  = 1'b1;
                TGT_IDX:  dec.ld_idx  = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/ctr_byte_ptr.sv
module ctr_byte_ptr
    import ctr_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rewind,
    input  logic      advance,
    output byte_ptr_e ptr
);
    byte_ptr_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PTR_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (rewind) begin
            state_d = PTR_LOW;
        end else if (advance) begin
            unique case (state_q)
                PTR_LOW:  state_d = PTR_MID;
                PTR_MID:  state_d = PTR_HIGH;
                PTR_HIGH: state_d = PTR_LOW;
                default:  state_d = PTR_LOW;
            endcase
        end
    end

    assign ptr = state_q;
endmodule

// File: rtl/ctr_data_regs.sv
module ctr_data_regs
    import ctr_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  ctl_dec_t          dec,
    input  logic              data_wr,
    input  byte_ptr_e         ptr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [VAL_W-1:0]  core_count,
    output logic [VAL_W-1:0]  preset_q,
    output logic [VAL_W-1:0]  latch_q,
    output logic [BYTE_W-1:0] psc_q,
    output logic [PAY_W-1:0]  mode_q,
    output logic [PAY_W-1:0]  ioc_q,
    output logic [PAY_W-1:0]  idx_q,
    output logic              stb_rst_cnt,
    output logic              stb_clr_flags,
    output logic              stb_clr_err,
    output logic              stb_preset
);
    logic [BYTE_W-1:0] preset_b [NUM_BYTES];

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_preset
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                preset_b[b] <= '0;
            else if (data_wr && (ptr == byte_ptr_e'(b)))
                preset_b[b] <= wdata;
        end
        assign preset_q[b*BYTE_W +: BYTE_W] = preset_b[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q       <= '0;
            psc_q         <= '0;
            mode_q        <= '0;
            ioc_q         <= '0;
            idx_q         <= '0;
            stb_rst_cnt   <= 1'b0;
            stb_clr_flags <= 1'b0;
            stb_clr_err   <= 1'b0;
            stb_preset    <= 1'b0;
        end else begin
            stb_rst_cnt   <= dec.rst_cnt;
            stb_clr_flags <= dec.clr_flags;
            stb_clr_err   <= dec.clr_err;
            stb_preset    <= dec.xfer_preset;
            if (dec.xfer_latch) latch_q <= core_count;
            if (dec.xfer_psc)   psc_q   <= preset_b[0];
            if (dec.ld_mode)    mode_q  <= dec.payload;
            if (dec.ld_ioc)     ioc_q   <= dec.payload;
            if (dec.ld_idx)     idx_q   <= dec.payload;
        end
    end
endmodule

// File: rtl/ctr_byte_port.sv
module ctr_byte_port
    import ctr_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [VAL_W-1:0]  core_count,
    input  logic              core_borrow,
    input  logic              core_carry,
    input  logic              core_error,
    input  logic              core_up,
    output logic              cmd_cnt_reset,
    output logic              cmd_flag_clear,
    output logic              cmd_err_clear,
    output logic              cmd_preset_load,
    output logic [VAL_W-1:0]  preset_value,
    output logic [BYTE_W-1:0] psc_value,
    output logic [PAY_W-1:0]  mode_cfg,
    output logic [PAY_W-1:0]  ioc_cfg,
    output logic [PAY_W-1:0]  idx_cfg
);
    logic             ctl_wr, data_wr, data_rd;
    ctl_dec_t         dec;
    byte_ptr_e        ptr;
    logic [1:0]       ptr_q;
    logic [VAL_W-1:0] latch_q;

    assign ctl_wr  = bus_wr &  bus_addr;
    assign data_wr = bus_wr & ~bus_addr;
    assign data_rd = bus_rd & ~bus_addr;

    ctr_ctl_decode u_dec (
        .ctl_valid (ctl_wr),
        .ctl_byte  (bus_wdata),
        .dec       (dec)
    );

    ctr_byte_ptr u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .rewind  (dec.rewind),
        .advance (data_wr | data_rd),
        .ptr     (ptr)
    );
    assign ptr_q = ptr;

    ctr_data_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .dec           (dec),
        .data_wr       (data_wr),
        .ptr           (ptr),
        .wdata         (bus_wdata),
        .core_count    (core_count),
        .preset_q      (preset_value),
        .latch_q       (latch_q),
        .psc_q         (psc_value),
        .mode_q        (mode_cfg),
        .ioc_q         (ioc_cfg),
        .idx_q         (idx_cfg),
        .stb_rst_cnt   (cmd_cnt_reset),
        .stb_clr_flags (cmd_flag_clear),
        .stb_clr_err   (cmd_err_clear),
        .stb_preset    (cmd_preset_load)
    );

    always_comb begin
        if (bus_addr) begin
            bus_rdata = {2'b00, core_up, core_error, 2'b00, core_carry, core_borrow};
        end else begin
            unique case (ptr)
                PTR_MID:  bus_rdata = latch_q[2*BYTE_W-1:BYTE_W];
                PTR_HIGH: bus_rdata = latch_q[3*BYTE_W-1:2*BYTE_W];
                default:  bus_rdata = latch_q[BYTE_W-1:0];
            endcase
        end
    end
endmodule

// File: rtl/ctr_byte_port_chk.sv
module ctr_byte_port_chk
    import ctr_port_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic              cmd_cnt_reset,
    input logic              cmd_flag_clear,
    input logic              cmd_err_clear,
    input logic [VAL_W-1:0]  preset_value,
    input logic [BYTE_W-1:0] psc_value,
    input logic [PAY_W-1:0]  mode_cfg,
    input logic [PAY_W-1:0]  ioc_cfg,
    input logic [PAY_W-1:0]  idx_cfg,
    input logic [1:0]        ptr_q
);
    logic is_cmd;
    assign is_cmd = bus_wr && bus_addr && (bus_wdata[6:5] == 2'b00);

    assert_ptr_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && !bus_addr && ptr_q == 2'd2) |=> (ptr_q == 2'd0));

    assert_rewind_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && bus_wdata[0]) |=> (ptr_q == 2'd0));

    assert_one_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_cnt_reset, cmd_flag_clear, cmd_err_clear}));

    assert_cnt_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && bus_wdata[2:1] == 2'b01) |=> cmd_cnt_reset);

    assert_psc_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && bus_wdata[4:3] == 2'b11) |=> (psc_value == $past(preset_value[BYTE_W-1:0])));

    assert_preset_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && !bus_addr) |=> $stable(preset_value));

    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr) |=> ($stable(mode_cfg) && $stable(ioc_cfg) && $stable(idx_cfg)));

    assert_cmd_keeps_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd |=> ($stable(mode_cfg) && $stable(ioc_cfg) && $stable(idx_cfg)));
endmodule

bind ctr_byte_port ctr_byte_port_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_wr         (bus_wr),
    .bus_rd         (bus_rd),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .cmd_cnt_reset  (cmd_cnt_reset),
    .cmd_flag_clear (cmd_flag_clear),
    .cmd_err_clear  (cmd_err_clear),
    .preset_value   (preset_value),
    .psc_value      (psc_value),
    .mode_cfg       (mode_cfg),
    .ioc_cfg        (ioc_cfg),
    .idx_cfg        (idx_cfg),
    .ptr_q          (ptr_q)
);

// File: tb/ctr_byte_port_tb.sv
module ctr_byte_port_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {control byte, expected mode, expected ioc, expected idx}
    localparam logic [31:0] CFG_VEC [NVEC] = '{
        32'h2B_0B_00_00, 32'h45_0B_05_00, 32'h63_0B_05_03,
        32'h20_00_05_03, 32'hDF_00_1F_03, 32'h01_00_1F_03
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_addr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [23:0] core_count;
    logic        core_borrow = 1'b0, core_carry = 1'b0, core_error = 1'b0, core_up = 1'b0;
    logic        cmd_cnt_reset, cmd_flag_clear, cmd_err_clear, cmd_preset_load;
    logic [23:0] preset_value;
    logic [7:0]  psc_value;
    logic [4:0]  mode_cfg, ioc_cfg, idx_cfg;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // counting-core stub: holds its value, clears or loads on strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               core_count <= '0;
        else if (cmd_cnt_reset)   core_count <= '0;
        else if (cmd_preset_load) core_count <= preset_value;
    end

    ctr_byte_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_count(core_count), .core_borrow(core_borrow), .core_carry(core_carry),
        .core_error(core_error), .core_up(core_up),
        .cmd_cnt_reset(cmd_cnt_reset), .cmd_flag_clear(cmd_flag_clear),
        .cmd_err_clear(cmd_err_clear), .cmd_preset_load(cmd_preset_load),
        .preset_value(preset_value), .psc_value(psc_value),
        .mode_cfg(mode_cfg), .ioc_cfg(ioc_cfg), .idx_cfg(idx_cfg)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read3(output logic [23:0] v);
        logic [7:0] b0, b1, b2;
        rd(1'b0, b0); rd(1'b0, b1); rd(1'b0, b2);
        v = {b2, b1, b0};
    endtask

    initial begin
        logic [23:0] v;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 cfg", {mode_cfg, ioc_cfg, idx_cfg}, 32'h0);
        check("R1 strobes", {cmd_cnt_reset, cmd_flag_clear, cmd_err_clear, cmd_preset_load}, 32'h0);
        check("R1 preset/psc", {preset_value, psc_value}, 32'h0);
        read3(v);
        check("R1 latch zero", v, 32'h0);

        // R9 / R10: configuration table
        for (int i = 0; i < NVEC; i++) begin
            wr(1'b1, CFG_VEC[i][31:24]);
            check("R9/R10 cfg table", {8'h0, 3'b0, mode_cfg, 3'b0, ioc_cfg, 3'b0, idx_cfg},
                  {8'h0, CFG_VEC[i][23:0]});
        end

        // R2: preset written low byte first
        wr(1'b1, 8'h01);
        wr(1'b0, 8'h56); wr(1'b0, 8'h34); wr(1'b0, 8'h12);
        check("R2 preset", preset_value, 32'h123456);
        // R3: fourth write wraps to low byte
        wr(1'b0, 8'hAA);
        check("R3 wrap", preset_value, 32'h1234AA);

        // R6: preset to counter strobe (with rewind)
        wr(1'b1, 8'h09);
        check("R6 preset strobe", cmd_preset_load, 32'h1);
        @(negedge clk);
        check("R6 core loaded", core_count, 32'h1234AA);

        // R7: latch and read back low byte first
        wr(1'b1, 8'h11);
        read3(v);
        check("R7 latch read", v, 32'h1234AA);
        check("R2 reads keep preset", preset_value, 32'h1234AA);

        // R4: without rewind the pointer keeps its position
        wr(1'b1, 8'h01);
        rd(1'b0, b);
        wr(1'b1, 8'h10);
        rd(1'b0, b);
        check("R4 no rewind keeps ptr", b, 32'h34);
        // R4: rewind with latch starts at low byte
        wr(1'b1, 8'h11);
        rd(1'b0, b);
        check("R4 rewind before read", b, 32'hAA);

        // R5: reset field decoding
        wr(1'b1, 8'h04);
        check("R5 flag clear", {cmd_cnt_reset, cmd_flag_clear, cmd_err_clear}, 32'h2);
        @(negedge clk);
        check("R5 one cycle", cmd_flag_clear, 32'h0);
        wr(1'b1, 8'h06);
        check("R5 err clear", {cmd_cnt_reset, cmd_flag_clear, cmd_err_clear}, 32'h1);
        wr(1'b1, 8'h00);
        check("R5 none", {cmd_cnt_reset, cmd_flag_clear, cmd_err_clear, cmd_preset_load}, 32'h0);

        // R5/R6: rewind + counter reset + latch in one byte
        wr(1'b1, 8'h13);
        check("R5 cnt reset strobe", {cmd_cnt_reset, cmd_flag_clear, cmd_err_clear}, 32'h4);
        read3(v);
        check("R6 latch before reset", v, 32'h1234AA);
        check("R5 core cleared", core_count, 32'h0);
        wr(1'b1, 8'h11);
        read3(v);
        check("R6 latch after reset", v, 32'h0);

        // R6: prescaler copy
        wr(1'b1, 8'h18);
        check("R6 psc", psc_value, 32'hAA);
        check("R10 cmd keeps cfg", {mode_cfg, ioc_cfg, idx_cfg}, {17'h0, 5'h00, 5'h1F, 5'h03});

        // R8: status byte
        core_borrow = 1'b1; core_up = 1'b1;
        rd(1'b1, b);
        check("R8 status a", b, 32'h21);
        core_borrow = 1'b0; core_up = 1'b0; core_carry = 1'b1; core_error = 1'b1;
        rd(1'b1, b);
        check("R8 status b", b, 32'h12);

        // R1: reset again in the middle of use
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 re-reset", {preset_value, psc_value}, 32'h0);
        check("R1 re-reset cfg", {mode_cfg, ioc_cfg, idx_cfg}, 32'h0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule